// File: doc/BRIEF.md
# Lockable Programmable Rate Divider

This block holds a 16-bit divisor in a 32-bit software-visible register and uses it to cut a half-rate module clock down to a periodic strobe at the interpolation rate. The module clock is not a separate clock net. An internal enable fires on every second cycle of the single input clock, so one module tick occurs every two clock cycles. While the run-control input `go_i` is high, a counter advances on each module tick. When it has counted the effective divisor, it emits a strobe one clock cycle wide and starts again.

Software picks the divisor as the rounded ratio of the module-clock rate to the wanted strobe rate. It writes the divisor only while `go_i` is low, because the register is locked while the block runs. A stored zero reads back as zero, but the counter treats it as one.

Top module: `rate_div_top`

## Requirements
- R1: After reset `rd_data_o` reads 0x00000001 and `strobe_o` is low.
- R2: `rd_data_o[31:16]` always reads zero; bits 31..16 of `wr_data_i` never change any read value.
- R3: A write (`wr_en_i` high at a rising edge) while `go_i` is low stores `wr_data_i[15:0]`, visible on `rd_data_o` from the next cycle.
- R4: A write while `go_i` is high is dropped and the stored field keeps its value.
- R5: A stored field of 0x0000 reads back as 0x0000, yet the strobe timing is exactly that of a divisor of 1.
- R6: One module tick occurs every second clock cycle (free-running from reset). While `go_i` stays high, `strobe_o` is high for exactly one cycle at a time, and consecutive strobes are 2×D clock cycles apart (D = effective divisor).
- R7: While `go_i` is low the counter is held cleared and `strobe_o` stays low. After `go_i` rises, the first strobe follows the D-th module tick that sees `go_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Run control; high runs the counter and locks the register |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| strobe_o | output | 1 | Rate strobe, one cycle wide |

## Verification
The hardest case to reach is a stored zero divisor while the block is running. A zero must be written with `go_i` low, then `go_i` raised, and the strobe spacing measured against a divisor of one. The same stimulus also shows that the read value stays zero. The bench also tries a write while running and then reads the register back to show the write was dropped. It drops `go_i` in mid-period to check that the counter restarts from zero. A per-cycle behavioural model follows the tick phase, so each strobe is predicted to the exact cycle.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned DIV_W = 16;
  localparam logic [DIV_W-1:0] DIV_RESET = 16'h0001;
endpackage

// File: rtl/rate_div_reg.sv
module rate_div_reg
  import rate_div_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_data_i,
  output logic [RW-1:0] rd_data_o,
  output logic [DW-1:0] eff_div_o
);
  localparam int unsigned PAD_W = RW - DW;

  logic [DW-1:0] field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                field_q <= DW'(DIV_RESET);
    else if (wr_en_i && !go_i)  field_q <= wr_data_i[DW-1:0];
  end

  assign rd_data_o = {{PAD_W{1'b0}}, field_q};
  // zero is illegal: count as one
  assign eff_div_o = (field_q == '0) ? DW'(1) : field_q;

  assert_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> $stable(field_q));
  assert_write_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !go_i) |=> (field_q == $past(wr_data_i[DW-1:0])));
endmodule

// File: rtl/rate_div_tick.sv
module rate_div_tick (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign tick_o = phase_q;

  assert_tick_alternates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rate_div_count.sv
module rate_div_count
  import rate_div_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          tick_i,
  input  logic [DW-1:0] eff_div_i,
  output logic          strobe_o
);
  logic [DW-1:0] cnt_q;
  logic          strobe_q;
  logic [DW:0]   cnt_inc;
  logic          wrap;

  assign cnt_inc = {1'b0, cnt_q} + (DW+1)'(1);
  assign wrap    = (cnt_inc >= {1'b0, eff_div_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (!go_i) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q    <= wrap ? '0 : cnt_inc[DW-1:0];
      strobe_q <= wrap;
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;

  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);
  assert_strobe_after_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_q) |-> $past(tick_i));
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> (!strobe_q && cnt_q == '0));
  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> (cnt_q < $past(eff_div_i)));
endmodule

// File: rtl/rate_div_top.sv
module rate_div_top
  import rate_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             strobe_o
);
  logic             tick;
  logic [DIV_W-1:0] eff_div;

  rate_div_reg #(.RW(REG_W), .DW(DIV_W)) u_reg (
    .clk_i, .rst_ni, .go_i, .wr_en_i, .wr_data_i,
    .rd_data_o, .eff_div_o(eff_div)
  );

  rate_div_tick u_tick (.clk_i, .rst_ni, .tick_o(tick));

  rate_div_count #(.DW(DIV_W)) u_cnt (
    .clk_i, .rst_ni, .go_i, .tick_i(tick), .eff_div_i(eff_div), .strobe_o
  );

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> (rd_data_o[REG_W-1:DIV_W] == '0));
endmodule

// File: tb/sim_rate_div_top.sv
module sim_rate_div_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        strobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference
  int m_phase = 0, m_cnt = 0, m_field = 1, m_strobe = 0;
  int last_strobe = -1;
  int exp_period = 0;
  int strobe_cnt = 0;

  always #5 clk = ~clk;

  rate_div_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .strobe_o(strobe)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int eff, nphase, ncnt, nstrobe, nfield;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_field = 1; m_strobe = 0;
    end else begin
      eff = (m_field == 0) ? 1 : m_field;
      nstrobe = 0; ncnt = m_cnt; nfield = m_field;
      if (!go) ncnt = 0;
      else if (m_phase == 1) begin
        if (m_cnt + 1 >= eff) begin ncnt = 0; nstrobe = 1; end
        else ncnt = m_cnt + 1;
      end
      if (wr_en && !go) nfield = int'(wr_data[15:0]);
      nphase = 1 - m_phase;
      m_phase = nphase; m_cnt = ncnt; m_strobe = nstrobe; m_field = nfield;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R2 R3 R4 read", rd_data, m_field);
      check("R2 reserved", rd_data[31:16], 0);
      check(go ? "R6 strobe" : "R7 idle strobe", strobe, m_strobe);
      if (!go) last_strobe = -1;
      if (strobe) begin
        strobe_cnt++;
        if (last_strobe >= 0 && exp_period != 0)
          check("R5 R6 period", cyc - last_strobe, exp_period);
        last_strobe = cyc;
      end
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(logic [31:0] d);
    wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  initial begin
    int s0;
    step(3);
    check("R1 reset read", rd_data, 32'h1);
    check("R1 reset strobe", strobe, 0);
    rst_n = 1'b1;
    step(1);
    check("R1 after release", rd_data, 32'h1);

    // divisor 1: strobe every second cycle
    exp_period = 2;
    go = 1'b1;
    step(20);

    // write while running is dropped
    write_reg(32'h0000_0005);
    step(1);
    check("R4 locked", rd_data, 32'h1);

    // reserved bits in write data
    go = 1'b0; step(2);
    write_reg(32'hABCD_0003);
    check("R3 R2 write", rd_data, 32'h3);
    exp_period = 6;
    s0 = strobe_cnt;
    go = 1'b1; step(40);
    check("R6 strobes seen", (strobe_cnt - s0) >= 5, 1);

    // stop mid-period
    step(3);
    go = 1'b0; step(10);
    check("R7 quiet", strobe, 0);

    // zero divisor
    write_reg(32'h0000_0000);
    check("R5 zero read", rd_data, 0);
    exp_period = 2;
    s0 = strobe_cnt;
    go = 1'b1; step(20);
    check("R5 zero runs", (strobe_cnt - s0) >= 8, 1);
    go = 1'b0; step(2);

    // larger divisor, odd restart alignment
    write_reg(32'hFFFF_0007);
    check("R3 R2 write 7", rd_data, 32'h7);
    step(1);
    exp_period = 14;
    go = 1'b1; step(60);
    write_reg(32'h0000_0002);
    check("R4 locked 7", rd_data, 32'h7);
    go = 1'b0; step(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule